// File: doc/BRIEF.md
# Reconfigurable Bit-Serial GF(2^m) Multiplier

This block multiplies two elements of a binary extension field GF(2^m) in polynomial basis. All additions are carry-less XORs, and every partial result is reduced modulo a field polynomial x^m + r(x). The low-order part r(x) sits in a register that can be rewritten at run time. The datapath is a shift register with feedback, sized once for the widest field `MAX_M`. It consumes one coefficient of operand b per clock, starting with the most significant one.

A caller selects one of five field widths with a small code. Narrower fields reuse the same register. The operands and the reduction term are shifted up to the top of the register when an operation starts, and the result is shifted back down when it ends. No multiplexer sits on the feedback wire. A start pulse begins an operation, busy covers the work, and a single-cycle done marks the cycle in which the product becomes valid.

Top module: `gfb_serial_mul`

## Requirements
- R1: After an accepted start with width w, `product` holds (a·b) mod (x^w + r(x)) in bits w-1..0 and zeros above. Bit i of a, b, `poly_data` and `product` is the coefficient of x^i.
- R2: `field_sel` codes 0, 1, 2, 3 and 4 select widths 163, 233, 283, 409 and 571. A start with codes 5 to 7, or with a width above `MAX_M`, is ignored: busy stays low and `product` is unchanged.
- R3: A start accepted while idle raises busy at the next edge. Busy stays high for exactly w cycles. At the edge where busy falls, done rises. A start in the cycle where done is high is accepted.
- R4: Done is high for exactly one cycle per operation, and `product` changes only in a cycle where done is high.
- R5: Start while busy is high has no effect on the running operation and begins no second one.
- R6: A `poly_we` pulse while idle loads r(x) from `poly_data`, and the x^w term is implicit. An operation started in the same cycle as such a write uses the previous r(x).
- R7: A `poly_we` pulse while busy is high is ignored.
- R8: Bits at positions w and above of `op_a`, `op_b` and the stored r(x) have no effect on the result.
- R9: During and after reset, busy, done and `product` are 0, and the stored r(x) is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a multiplication when idle |
| field_sel | input | 3 | Field width code |
| poly_we | input | 1 | Write strobe for the reduction term |
| poly_data | input | MAX_M | Reduction term r(x), bit i is x^i |
| op_a | input | MAX_M | Multiplicand a |
| op_b | input | MAX_M | Multiplier b, fed serially MSB first |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse, product valid |
| product | output | MAX_M | Reduced product, right-aligned |

## Verification
The bench first uses the single-term pair x·x^(w-1), which forces exactly one reduction. Its result equals the stored r(x), so it reveals the polynomial register's contents and any write that should have been ignored. Products of 1·1 separate shift and alignment errors from reduction errors. All-ones operands drive the feedback on almost every step. Random operands in each of the five fields test the alignment for every shift amount. Operands and polynomials with garbage above bit w-1 show whether the masking works. Starts during busy, with invalid codes, and polynomial writes during busy or in the same cycle as a start exercise the acceptance rules.

// File: rtl/gfb_pkg.sv
package gfb_pkg;

    localparam int NUM_FIELDS = 5;
    localparam int SEL_W      = 3;

    // Width of the field selected by a code; 0 marks an unused code.
    function automatic int field_width(input logic [SEL_W-1:0] sel);
        case (sel)
            3'd0:    return 163;
            3'd1:    return 233;
            3'd2:    return 283;
            3'd3:    return 409;
            3'd4:    return 571;
            default: return 0;
        endcase
    endfunction

    function automatic logic field_ok(input logic [SEL_W-1:0] sel, input int max_m);
        return (field_width(sel) != 0) && (field_width(sel) <= max_m);
    endfunction

endpackage

// File: rtl/gfb_align.sv
// Fixed-amount shifter: moves a field element between its natural position
// and the top of the MAX_M register. One constant shift per field, chosen by sel.
module gfb_align #(
    parameter int MAX_M = 571,
    parameter bit LEFT  = 1'b1
) (
    input  logic [MAX_M-1:0]           din,
    input  logic [gfb_pkg::SEL_W-1:0]  sel,
    output logic [MAX_M-1:0]           dout
);
    import gfb_pkg::*;

    logic [MAX_M-1:0] cand [NUM_FIELDS];

    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
        localparam int W  = field_width(SEL_W'(f));
        localparam int SH = (W <= MAX_M) ? (MAX_M - W) : 0;
        if (W > MAX_M) begin : g_absent
            assign cand[f] = '0;
        end else if (LEFT) begin : g_up
            assign cand[f] = din << SH;
        end else begin : g_down
            assign cand[f] = din >> SH;
        end
    end

    always_comb begin
        dout = '0;
        for (int f = 0; f < NUM_FIELDS; f++) begin
            if (sel == SEL_W'(f)) dout = cand[f];
        end
    end

endmodule

// File: rtl/gfb_step.sv
// One MSB-first step: shift left, fold the overflow bit back through the
// AND-gated reduction term, then add the multiplicand if the b bit is set.
module gfb_step #(
    parameter int MAX_M = 571
) (
    input  logic [MAX_M-1:0] acc,
    input  logic [MAX_M-1:0] mult,
    input  logic [MAX_M-1:0] poly,
    input  logic             bit_in,
    output logic [MAX_M-1:0] acc_nx
);
    logic fb;
    assign fb = acc[MAX_M-1];

    for (genvar i = 0; i < MAX_M; i++) begin : g_bit
        if (i == 0) begin : g_low
            assign acc_nx[i] = (fb & poly[i]) ^ (bit_in & mult[i]);
        end else begin : g_mid
            assign acc_nx[i] = acc[i-1] ^ (fb & poly[i]) ^ (bit_in & mult[i]);
        end
    end

endmodule

// File: rtl/gfb_serial_mul.sv
module gfb_serial_mul #(
    parameter int MAX_M = 571
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [2:0]                field_sel,
    input  logic                      poly_we,
    input  logic [MAX_M-1:0]          poly_data,
    input  logic [MAX_M-1:0]          op_a,
    input  logic [MAX_M-1:0]          op_b,
    output logic                      busy,
    output logic                      done,
    output logic [MAX_M-1:0]          product
);
    import gfb_pkg::*;

    localparam int CNT_W = $clog2(MAX_M + 1);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [CNT_W-1:0] cnt;
        logic [SEL_W-1:0] sel;
        logic [MAX_M-1:0] acc;
        logic [MAX_M-1:0] mult;
        logic [MAX_M-1:0] red;
        logic [MAX_M-1:0] bser;
        logic [MAX_M-1:0] poly;
        logic [MAX_M-1:0] prod;
    } state_t;

    state_t s_q, s_d;

    logic [MAX_M-1:0] a_up, b_up, p_up, acc_nx, prod_nx;

    gfb_align #(.MAX_M(MAX_M), .LEFT(1'b1)) u_up_a (
        .din(op_a), .sel(field_sel), .dout(a_up));
    gfb_align #(.MAX_M(MAX_M), .LEFT(1'b1)) u_up_b (
        .din(op_b), .sel(field_sel), .dout(b_up));
    gfb_align #(.MAX_M(MAX_M), .LEFT(1'b1)) u_up_p (
        .din(s_q.poly), .sel(field_sel), .dout(p_up));

    gfb_step #(.MAX_M(MAX_M)) u_step (
        .acc(s_q.acc), .mult(s_q.mult), .poly(s_q.red),
        .bit_in(s_q.bser[MAX_M-1]), .acc_nx(acc_nx));

    gfb_align #(.MAX_M(MAX_M), .LEFT(1'b0)) u_down (
        .din(acc_nx), .sel(s_q.sel), .dout(prod_nx));

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (s_q.busy) begin
            s_d.acc  = acc_nx;
            s_d.bser = s_q.bser << 1;
            s_d.cnt  = s_q.cnt - CNT_W'(1);
            if (s_q.cnt == CNT_W'(1)) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
                s_d.prod = prod_nx;
            end
        end else if (start && field_ok(field_sel, MAX_M)) begin
            s_d.busy = 1'b1;
            s_d.cnt  = CNT_W'(field_width(field_sel));
            s_d.sel  = field_sel;
            s_d.acc  = '0;
            s_d.mult = a_up;
            s_d.red  = p_up;
            s_d.bser = b_up;
        end
        if (poly_we && !s_q.busy) begin
            s_d.poly = poly_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy    = s_q.busy;
    assign done    = s_q.done;
    assign product = s_q.prod;

endmodule

// File: rtl/gfb_serial_mul_chk.sv
module gfb_serial_mul_chk #(
    parameter int MAX_M = 571
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [2:0]       field_sel,
    input logic             busy,
    input logic             done,
    input logic [MAX_M-1:0] product
);
    import gfb_pkg::*;

    int run_q;
    int exp_q;
    logic take;
    assign take = start && !busy && field_ok(field_sel, MAX_M);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 0;
            exp_q <= 0;
        end else if (take) begin
            run_q <= 0;
            exp_q <= field_width(field_sel);
        end else if (busy) begin
            run_q <= run_q + 1;
        end
    end

    // R3
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> busy);

    // R3
    run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_q == exp_q));

    // R3
    fall_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R4
    one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4
    prod_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(product));

    // R2
    bad_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !field_ok(field_sel, MAX_M)) |=> !busy);

endmodule

bind gfb_serial_mul gfb_serial_mul_chk #(.MAX_M(MAX_M)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .field_sel(field_sel),
    .busy(busy), .done(done), .product(product));

// File: tb/gfb_serial_mul_test.sv
module gfb_serial_mul_test;

    localparam int MM = 571;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [2:0]    field_sel = 3'd0;
    logic          poly_we = 1'b0;
    logic [MM-1:0] poly_data = '0;
    logic [MM-1:0] op_a = '0;
    logic [MM-1:0] op_b = '0;
    logic          busy, done;
    logic [MM-1:0] product;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    gfb_serial_mul #(.MAX_M(MM)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .field_sel(field_sel),
        .poly_we(poly_we), .poly_data(poly_data), .op_a(op_a), .op_b(op_b),
        .busy(busy), .done(done), .product(product));

    function automatic int fw(input logic [2:0] s);
        case (s)
            3'd0: return 163;
            3'd1: return 233;
            3'd2: return 283;
            3'd3: return 409;
            3'd4: return 571;
            default: return 0;
        endcase
    endfunction

    function automatic logic [MM-1:0] lowmask(input int w);
        logic [MM-1:0] m;
        for (int i = 0; i < MM; i++) m[i] = (i < w);
        return m;
    endfunction

    // Schoolbook carry-less product followed by long division.
    function automatic logic [MM-1:0] ref_mul(input logic [MM-1:0] a,
        input logic [MM-1:0] b, input logic [MM-1:0] r, input int w);
        logic [2*MM-1:0] full;
        logic [2*MM-1:0] modp;
        full = '0;
        for (int i = 0; i < w; i++)
            if (b[i])
                for (int j = 0; j < w; j++)
                    if (a[j]) full[i+j] = ~full[i+j];
        modp = '0;
        modp[MM-1:0] = r & lowmask(w);
        modp[w] = 1'b1;
        for (int d = 2*w-2; d >= w; d--)
            if (full[d]) full = full ^ (modp << (d - w));
        return full[MM-1:0];
    endfunction

    function automatic logic [MM-1:0] rnd();
        logic [MM-1:0] v;
        for (int i = 0; i < MM; i++) v[i] = 1'($urandom % 2);
        return v;
    endfunction

    function automatic logic [MM-1:0] mono(input int k);
        logic [MM-1:0] v;
        v = '0;
        v[k] = 1'b1;
        return v;
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [MM-1:0] act, input logic [MM-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Cycle model
    logic          m_busy = 1'b0, m_done = 1'b0, ob;
    logic [MM-1:0] m_prod = '0, m_poly = '0, m_res = '0;
    int            m_cnt = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 1'b0; m_done = 1'b0; m_prod = '0; m_poly = '0; m_cnt = 0;
        end else begin
            ob = m_busy;
            m_done = 1'b0;
            if (m_busy) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    m_busy = 1'b0; m_done = 1'b1; m_prod = m_res;
                end
            end else if (start && fw(field_sel) != 0) begin
                m_busy = 1'b1;
                m_cnt  = fw(field_sel);
                m_res  = ref_mul(op_a, op_b, m_poly, fw(field_sel));
            end
            if (poly_we && !ob) m_poly = poly_data;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(busy == m_busy, "R3 busy vs model", MM'(busy), MM'(m_busy));
            check(done == m_done, "R4 done vs model", MM'(done), MM'(m_done));
            check(product == m_prod, "R1 product vs model", product, m_prod);
        end
    end

    task automatic write_poly(input logic [MM-1:0] p);
        @(negedge clk);
        poly_we = 1'b1; poly_data = p;
        @(negedge clk);
        poly_we = 1'b0;
    endtask

    task automatic run_op(input logic [2:0] s, input logic [MM-1:0] a,
                          input logic [MM-1:0] b, input logic [MM-1:0] exp,
                          input string tag);
        int n;
        @(negedge clk);
        field_sel = s; op_a = a; op_b = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && n < 2000) begin
            @(negedge clk);
            n++;
        end
        check(n == fw(s), "R3 cycles start to done", MM'(n), MM'(fw(s)));
        check(product == exp, tag, product, exp);
    endtask

    task automatic summary();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL R3 watchdog expired actual=hung expected=finish");
        summary();
        $finish;
    end

    localparam logic [MM-1:0] P163 = MM'('hC9);

    initial begin
        logic [MM-1:0] a, b, keep, pw [5];
        pw[0] = P163;
        pw[1] = mono(74) | MM'(1);
        pw[2] = mono(12) | mono(7) | mono(5) | MM'(1);
        pw[3] = mono(87) | MM'(1);
        pw[4] = mono(10) | mono(5) | mono(2) | MM'(1);

        repeat (3) @(negedge clk);
        // R9 reset state
        check(busy == 1'b0, "R9 busy in reset", MM'(busy), '0);
        check(done == 1'b0, "R9 done in reset", MM'(done), '0);
        check(product == '0, "R9 product in reset", product, '0);
        rst_n = 1'b1;

        // R9 stored r(x) is 0 after reset: x * x^162 reduces to 0
        run_op(3'd0, MM'(2), mono(162), '0, "R9 reset poly");

        // R6 load r(x), R1 simple products
        write_poly(P163);
        run_op(3'd0, MM'(1), MM'(1), MM'(1), "R1 one times one");
        run_op(3'd0, MM'(2), mono(162), P163, "R6 single reduction gives r");

        // R1 all-ones operands
        a = lowmask(163);
        run_op(3'd0, a, a, ref_mul(a, a, P163, 163), "R1 all ones");

        // R1 R2 random operands in each field
        for (int f = 0; f < 5; f++) begin
            write_poly(pw[f]);
            a = rnd() & lowmask(fw(3'(f)));
            b = rnd() & lowmask(fw(3'(f)));
            run_op(3'(f), a, b, ref_mul(a, b, pw[f], fw(3'(f))), "R2 field width random");
            run_op(3'(f), MM'(2), mono(fw(3'(f)) - 1), pw[f], "R1 reduction per field");
        end

        // R8 garbage above bit w-1
        write_poly(P163 | mono(400));
        a = rnd() & lowmask(163);
        b = rnd() & lowmask(163);
        run_op(3'd0, a | ~lowmask(163), b | ~lowmask(163),
               ref_mul(a, b, P163, 163), "R8 high operand bits ignored");
        run_op(3'd0, MM'(2), mono(162), P163, "R8 high poly bits ignored");

        // R2 invalid code
        keep = product;
        @(negedge clk);
        field_sel = 3'd5; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b0, "R2 invalid code busy", MM'(busy), '0);
        repeat (3) @(negedge clk);
        check(product == keep, "R2 invalid code product", product, keep);

        // R5 start while busy
        write_poly(P163);
        a = rnd() & lowmask(163);
        b = rnd() & lowmask(163);
        keep = ref_mul(a, b, P163, 163);
        @(negedge clk);
        field_sel = 3'd0; op_a = a; op_b = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        op_a = rnd(); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        check(product == keep, "R5 busy start ignored", product, keep);
        @(negedge clk);
        check(busy == 1'b0, "R5 no second run", MM'(busy), '0);

        // R7 poly write while busy
        @(negedge clk);
        field_sel = 3'd0; op_a = a; op_b = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        poly_we = 1'b1; poly_data = MM'('h1B);
        @(negedge clk);
        poly_we = 1'b0;
        while (!done) @(negedge clk);
        run_op(3'd0, MM'(2), mono(162), P163, "R7 write during busy ignored");

        // R6 write in the same cycle as start: old r used, new r kept
        @(negedge clk);
        field_sel = 3'd0; op_a = MM'(2); op_b = mono(162); start = 1'b1;
        poly_we = 1'b1; poly_data = MM'('h1B);
        @(negedge clk);
        start = 1'b0; poly_we = 1'b0;
        while (!done) @(negedge clk);
        check(product == P163, "R6 same-cycle write uses old r", product, P163);
        // R3 back-to-back: start while done is high
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R3 start at done accepted", MM'(busy), MM'(1));
        while (!done) @(negedge clk);
        check(product == MM'('h1B), "R6 new r after write", product, MM'('h1B));

        repeat (2) @(negedge clk);
        summary();
        $finish;
    end

endmodule